// File: doc/BRIEF.md
# Transmit List Doorbell Pair Checker

This block is a register slave that takes host posts of transmit descriptor lists. A post is made of two full 64-bit register writes. The first write carries the list address and the second carries the list control word. The block checks that the two writes come in that order and that every byte lane is enabled on each one. When a pair is valid, the block decodes the control word into a work request and places it in a small queue. A DMA engine drains that queue with a valid/ready handshake.

Any access pattern that breaks the protocol sets a sticky error bit and drops any list address that was waiting for its control word. Software reads the error bits and a wrapping counter of accepted posts from a status word. It clears error bits by writing ones to them.

Word addresses are fixed: 0 holds the list address, 1 holds the control word, and 2 is the status word. The control word layout is as follows. Bits [7:0] hold the index of the last descriptor, which is the descriptor count minus one. Bit 8 is the segmentation-offload special-function flag. Bits [10:9] are the no-snoop attribute bits.

Top module: `txlist_doorbell`

## Requirements
- R1: An address write to word 0 followed by a control write to word 1, both with all eight byte enables set, produces exactly one request whose `req_ptr` equals the written address.
- R2: `req_count` equals control bits [7:0] plus one: a field of 0 gives 1 and a field of 255 gives 256.
- R3: Control bit 8 appears on `req_special`, and control bits [10:9] appear unchanged on `req_nosnoop`.
- R4: A control write with no address pending sets status bit 0 (sequence error) and produces no request.
- R5: Two address writes in a row set status bit 0 and discard the pending address, so the control write that follows also sets bit 0 and produces no request.
- R6: An address or control write with any byte enable clear sets status bit 1 (partial write), discards the pending address and produces no request.
- R7: The request queue holds 4 entries. A control write that arrives while the queue is full sets status bit 2 (overflow), is not queued and is not counted.
- R8: Error bits stay set until software writes to word 2. Each data bit [2:0] written as 1 clears the matching error bit, and bits written as 0 leave their error bits unchanged.
- R9: Status bits [15:8] count accepted posts. The count rises by one for each queued request and wraps from 255 to 0.
- R10: Requests leave the queue in posting order, and each one is held stable while `req_valid` is high and `req_ready` is low. After reset the queue is empty and the status word is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Word address: 0 list address, 1 control, 2 status |
| wr_data | input | 64 | Write data |
| wr_be | input | 8 | Byte enables, one per byte lane |
| req_valid | output | 1 | Queue head holds a request |
| req_ready | input | 1 | DMA engine takes the head request |
| req_ptr | output | 64 | Descriptor list address |
| req_count | output | 9 | Number of descriptors, 1 to 256 |
| req_special | output | 1 | Segmentation-offload special-function flag |
| req_nosnoop | output | 2 | No-snoop attribute bits |
| stat_word | output | 16 | Count of accepted posts in [15:8], error bits in [2:0] |

## Verification
The main function is driven with several control words: the smallest descriptor field (0), the largest (255), and mixed flag patterns. These show whether the count decode is off by one and whether the flag bits are swapped or lost. The protocol is then broken in three ways: a control write with no address pending, two address writes back to back, and partial byte enables on each word. Each break must set its own error bit and leave no request behind, which separates the sequence error from the partial-write error. With the sink stalled, the queue is filled to its edge to show where overflow begins. A long run of posts shows the counter wrapping. Selective clears show that clearing one error bit leaves the others set.

// File: rtl/txdb_pkg.sv
package txdb_pkg;
  localparam int DATA_W   = 64;
  localparam int BE_W     = DATA_W / 8;
  localparam int IDX_W    = 8;
  localparam int COUNT_W  = IDX_W + 1;
  localparam int NS_W     = 2;
  localparam int SPEC_BIT = IDX_W;
  localparam int NS_LSB   = IDX_W + 1;
  localparam int ERR_N    = 3;

  localparam logic [1:0] A_PTR  = 2'd0;
  localparam logic [1:0] A_CTL  = 2'd1;
  localparam logic [1:0] A_STAT = 2'd2;

  localparam int E_SEQ  = 0;
  localparam int E_PART = 1;
  localparam int E_OVF  = 2;

  typedef struct packed {
    logic [DATA_W-1:0]  ptr;
    logic [COUNT_W-1:0] count;
    logic               special;
    logic [NS_W-1:0]    nosnoop;
  } txdb_req_t;

  localparam int REQ_W = $bits(txdb_req_t);
endpackage

// File: rtl/txdb_seq.sv
module txdb_seq
  import txdb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [BE_W-1:0]   wr_be,
  input  logic              q_full,
  output logic              q_push,
  output txdb_req_t         q_item,
  output logic [ERR_N-1:0]  err_set,
  output logic              ptr_pend
);
  logic              pend_q, pend_d;
  logic [DATA_W-1:0] ptr_q;
  logic              ptr_ld;
  logic              all_lanes;

  assign all_lanes = &wr_be;

  always_comb begin
    pend_d  = pend_q;
    ptr_ld  = 1'b0;
    q_push  = 1'b0;
    err_set = '0;
    if (wr_en) begin
      unique case (wr_addr)
        A_PTR: begin
          if (!all_lanes) begin
            err_set[E_PART] = 1'b1;
            pend_d          = 1'b0;
          end else if (pend_q) begin
            err_set[E_SEQ] = 1'b1;
            pend_d         = 1'b0;
          end else begin
            pend_d = 1'b1;
            ptr_ld = 1'b1;
          end
        end
        A_CTL: begin
          if (!all_lanes) begin
            err_set[E_PART] = 1'b1;
            pend_d          = 1'b0;
          end else if (!pend_q) begin
            err_set[E_SEQ] = 1'b1;
          end else if (q_full) begin
            err_set[E_OVF] = 1'b1;
            pend_d         = 1'b0;
          end else begin
            q_push = 1'b1;
            pend_d = 1'b0;
          end
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    q_item.ptr     = ptr_q;
    q_item.count   = COUNT_W'(wr_data[IDX_W-1:0]) + COUNT_W'(1);
    q_item.special = wr_data[SPEC_BIT];
    q_item.nosnoop = wr_data[NS_LSB +: NS_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_ld) ptr_q <= wr_data;
  end

  assign ptr_pend = pend_q;
endmodule

// File: rtl/txdb_status.sv
module txdb_status
  import txdb_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ERR_N-1:0] err_set,
  input  logic             clr_en,
  input  logic [ERR_N-1:0] clr_mask,
  input  logic             post_inc,
  output logic [ERR_N-1:0] err_q,
  output logic [CNT_W-1:0] cnt_q
);
  logic [ERR_N-1:0] err_d;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    err_d = err_q;
    if (clr_en) err_d = err_d & ~clr_mask;
    err_d = err_d | err_set;
    cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= '0;
    else        err_q <= err_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (post_inc) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/txdb_fifo.sv
module txdb_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         full,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [LW-1:0] lvl_q, lvl_d;
  logic          do_push, do_pop;

  assign full    = (lvl_q == LW'(DEPTH));
  assign empty   = (lvl_q == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rp_q];

  always_comb begin
    wp_d  = do_push ? ((wp_q == LAST) ? '0 : wp_q + AW'(1)) : wp_q;
    rp_d  = do_pop  ? ((rp_q == LAST) ? '0 : rp_q + AW'(1)) : rp_q;
    lvl_d = lvl_q;
    if (do_push && !do_pop) lvl_d = lvl_q + LW'(1);
    if (do_pop && !do_push) lvl_d = lvl_q - LW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      lvl_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      lvl_q <= lvl_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= push_data;
  end
endmodule

// File: rtl/txlist_doorbell.sv
module txlist_doorbell
  import txdb_pkg::*;
#(
  parameter int QDEPTH = 4,
  parameter int CNT_W  = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [1:0]          wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic [BE_W-1:0]     wr_be,
  output logic                req_valid,
  input  logic                req_ready,
  output logic [DATA_W-1:0]   req_ptr,
  output logic [COUNT_W-1:0]  req_count,
  output logic                req_special,
  output logic [NS_W-1:0]     req_nosnoop,
  output logic [CNT_W+7:0]    stat_word
);
  logic             q_push, q_full, q_empty, q_pop;
  txdb_req_t        q_item, q_head;
  logic [ERR_N-1:0] err_set, err_q;
  logic [CNT_W-1:0] post_cnt;
  logic             ptr_pend;
  logic             clr_en;

  txdb_seq u_seq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_be(wr_be), .q_full(q_full),
    .q_push(q_push), .q_item(q_item), .err_set(err_set), .ptr_pend(ptr_pend)
  );

  assign clr_en = wr_en && (wr_addr == A_STAT);

  txdb_status #(.CNT_W(CNT_W)) u_stat (
    .clk(clk), .rst_n(rst_n), .err_set(err_set), .clr_en(clr_en),
    .clr_mask(wr_data[ERR_N-1:0]), .post_inc(q_push),
    .err_q(err_q), .cnt_q(post_cnt)
  );

  txdb_fifo #(.W(REQ_W), .DEPTH(QDEPTH)) u_q (
    .clk(clk), .rst_n(rst_n), .push(q_push), .push_data(q_item),
    .pop(q_pop), .head(q_head), .full(q_full), .empty(q_empty)
  );

  assign req_valid   = !q_empty;
  assign q_pop       = req_valid && req_ready;
  assign req_ptr     = q_head.ptr;
  assign req_count   = q_head.count;
  assign req_special = q_head.special;
  assign req_nosnoop = q_head.nosnoop;
  assign stat_word   = {post_cnt, {(8-ERR_N){1'b0}}, err_q};
endmodule

// File: rtl/txdb_checker.sv
module txdb_checker
  import txdb_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [1:0]        wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic [BE_W-1:0]   wr_be,
  input logic              ptr_pend,
  input logic              q_push,
  input logic              q_full,
  input logic [ERR_N-1:0]  err_q,
  input logic [CNT_W-1:0]  post_cnt,
  input logic              req_valid,
  input logic              req_ready,
  input logic [DATA_W-1:0] req_ptr
);
  logic [ERR_N-1:0] keep;
  assign keep = (wr_en && wr_addr == A_STAT) ? (err_q & ~wr_data[ERR_N-1:0]) : err_q;

  // R4: control with nothing pending flags a sequence error
  p_seq_err_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_CTL && (&wr_be) && !ptr_pend) |=> err_q[E_SEQ]);

  // R6: partial lanes flag an error and drop the pending address
  p_partial_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_addr == A_PTR || wr_addr == A_CTL) && !(&wr_be))
      |=> (err_q[E_PART] && !ptr_pend));

  // R7: nothing is pushed into a full queue
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    q_push |-> !q_full);

  // R8: error bits not cleared stay set
  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((err_q & $past(keep)) == $past(keep)));

  // R9: accepted post advances the counter by one
  p_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
    q_push |=> (post_cnt == CNT_W'($past(post_cnt) + CNT_W'(1))));

  // R10: stalled head holds
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_ptr)));
endmodule

bind txlist_doorbell txdb_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .wr_be(wr_be), .ptr_pend(ptr_pend),
  .q_push(q_push), .q_full(q_full), .err_q(err_q), .post_cnt(post_cnt),
  .req_valid(req_valid), .req_ready(req_ready), .req_ptr(req_ptr)
);

// File: tb/txlist_doorbell_tb_top.sv
module txlist_doorbell_tb_top;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [63:0] p;
    logic [8:0]  c;
    logic        s;
    logic [1:0]  n;
  } exp_t;

  logic        clk, rst_n;
  logic        wr_en;
  logic [1:0]  wr_addr;
  logic [63:0] wr_data;
  logic [7:0]  wr_be;
  logic        req_valid, req_ready;
  logic [63:0] req_ptr;
  logic [8:0]  req_count;
  logic        req_special;
  logic [1:0]  req_nosnoop;
  logic [15:0] stat_word;

  exp_t exp_q[$];
  int   checks = 0;
  int   errors = 0;
  int   exp_cnt = 0;
  bit   done = 0;

  txlist_doorbell dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_be(wr_be), .req_valid(req_valid),
    .req_ready(req_ready), .req_ptr(req_ptr), .req_count(req_count),
    .req_special(req_special), .req_nosnoop(req_nosnoop),
    .stat_word(stat_word)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops expected items as the design hands them over
  always @(negedge clk) begin
    if (rst_n && req_valid && req_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R4/R5/R6/R7 unexpected request", req_ptr, 64'h0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(req_ptr == e.p, "R1/R10 pointer", req_ptr, e.p);
        check(req_count == e.c, "R2 count", 64'(req_count), 64'(e.c));
        check({req_nosnoop, req_special} == {e.n, e.s}, "R3 flags",
              64'({req_nosnoop, req_special}), 64'({e.n, e.s}));
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [63:0] d, input logic [7:0] be);
    wr_en = 1'b1; wr_addr = a; wr_data = d; wr_be = be;
    @(posedge clk); #1;
    wr_en = 1'b0; wr_be = 8'h00;
  endtask

  task automatic post(input logic [63:0] p, input logic [7:0] last, input bit s,
                      input logic [1:0] n, input bit acc);
    exp_t e;
    wr(2'd0, p, 8'hFF);
    if (acc) begin
      e.p = p; e.c = 9'(last) + 9'd1; e.s = s; e.n = n;
      exp_q.push_back(e);
      exp_cnt = (exp_cnt + 1) % 256;
    end
    wr(2'd1, {53'h0, n, s, last}, 8'hFF);
  endtask

  task automatic drain();
    for (int i = 0; i < 50 && exp_q.size() != 0; i++) begin
      @(posedge clk); #1;
    end
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic chk_stat(input logic [2:0] err, input string req);
    logic [15:0] e;
    e = {8'(exp_cnt), 5'b0, err};
    check(stat_word == e, req, 64'(stat_word), 64'(e));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; wr_be = '0;
    req_ready = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;

    // R10 reset state
    check(req_valid == 1'b0, "R10 reset valid", 64'(req_valid), 64'h0);
    chk_stat(3'b000, "R10 reset status");

    // R1 R2 R3 main function, several control patterns
    post(64'h0000_1234_5678_9A00, 8'd0,   1'b0, 2'b00, 1);
    post(64'hFFFF_0000_AAAA_5500, 8'd255, 1'b1, 2'b11, 1);
    post(64'h0123_4567_89AB_CDE0, 8'd7,   1'b1, 2'b01, 1);
    post(64'h8000_0000_0000_0040, 8'd128, 1'b0, 2'b10, 1);
    drain();
    chk_stat(3'b000, "R9 count after four posts");

    // R4 control with no pending pointer
    wr(2'd1, 64'h5, 8'hFF);
    check(stat_word[0] == 1'b1, "R4 seq error bit", 64'(stat_word), 64'h1);
    drain();
    check(req_valid == 1'b0, "R4 no request", 64'(req_valid), 64'h0);
    chk_stat(3'b001, "R4 status");

    // R8 clear
    wr(2'd2, 64'h7, 8'hFF);
    chk_stat(3'b000, "R8 clear all");

    // R5 two pointers in a row, then control also refused
    wr(2'd0, 64'h1000, 8'hFF);
    wr(2'd0, 64'h2000, 8'hFF);
    chk_stat(3'b001, "R5 double pointer");
    wr(2'd2, 64'h1, 8'hFF);
    wr(2'd1, 64'h3, 8'hFF);
    drain();
    chk_stat(3'b001, "R5 pending discarded");
    wr(2'd2, 64'h1, 8'hFF);

    // R6 partial pointer, then control refused
    wr(2'd0, 64'h3000, 8'h7F);
    chk_stat(3'b010, "R6 partial pointer");
    wr(2'd1, 64'h0, 8'hFF);
    drain();
    chk_stat(3'b011, "R6 pointer dropped");
    wr(2'd2, 64'h3, 8'hFF);

    // R6 partial control after valid pointer
    wr(2'd0, 64'h4000, 8'hFF);
    wr(2'd1, 64'h0, 8'hFE);
    drain();
    chk_stat(3'b010, "R6 partial control");
    check(req_valid == 1'b0, "R6 no request", 64'(req_valid), 64'h0);
    wr(2'd2, 64'h2, 8'hFF);

    // R7 overflow with stalled sink
    req_ready = 1'b0;
    for (int i = 0; i < 4; i++)
      post(64'h5000 + 64'(i * 64), 8'(i), i[0], 2'(i), 1);
    chk_stat(3'b000, "R7 four entries fit");
    post(64'h9000, 8'd9, 1'b0, 2'b00, 0);
    chk_stat(3'b100, "R7 overflow bit");
    check(req_ptr == 64'h5000, "R10 head held while stalled", req_ptr, 64'h5000);
    req_ready = 1'b1;
    drain();
    check(exp_q.size() == 0, "R7 queue drained", 64'(exp_q.size()), 64'h0);

    // R8 selective clear: set seq too, clear only overflow
    wr(2'd1, 64'h0, 8'hFF);
    chk_stat(3'b101, "R8 two sticky bits");
    wr(2'd2, 64'h4, 8'hFF);
    chk_stat(3'b001, "R8 selective clear");
    wr(2'd2, 64'h1, 8'hFF);

    // R9 counter wrap
    for (int i = 0; i < 250; i++)
      post(64'h10_0000 + 64'(i * 32), 8'(i), 1'b0, 2'b00, 1);
    drain();
    chk_stat(3'b000, "R9 counter wrap");
    check(stat_word[15:8] == 8'd2, "R9 wrapped value", 64'(stat_word[15:8]), 64'd2);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule